// File: doc/BRIEF.md
# Serial Receiver with Line Status

This block is the receive half of an asynchronous serial port. A free-running tick, sixteen per bit period, comes from a baud generator outside the block. The block uses it to oversample the incoming line. It finds and validates start bits, then shifts in five to eight data bits, least significant first. It also checks an optional parity bit and the stop position. Each finished character goes into a sixteen-entry receive queue together with its own parity, framing and break flags.

Software-side logic sees three things: the oldest queued byte, a line-status byte and a fill-level flag. The fill-level flag is raised once the queue reaches a selectable depth. A one-cycle data-read strobe removes the oldest byte. A one-cycle status-read strobe clears the sticky error bits. The error summary bit (bit 7) only clears on a status read if no flagged character is left in the queue. Two status bits are taken straight from the companion transmitter.

Top module: `uart_rx_linestat`

## Requirements
- R1: After a valid frame, the received byte appears on `rx_byte` and status bit 0 (data ready) is 1 while the queue is not empty. After reset the status reads 0x00 with the transmitter inputs low, and `rx_byte` is 0.
- R2: `char_len` selects 5, 6, 7 or 8 data bits for codes 00, 01, 10 and 11. Bits arrive least significant first, and unused upper bits of the stored byte are 0.
- R3: With `par_on`=1 a parity bit follows the data. Its expected value is set by `par_kind`: 00 odd, 01 even, 10 always 1, 11 always 0. A mismatch sets status bit 2.
- R4: A stop position sampled low after a frame with at least one 1 bit stores the byte and sets status bit 3.
- R5: A line held low for a whole frame, stop position included, stores exactly one 0x00 byte and sets status bit 4. No further character starts until the line has gone high again.
- R6: A start is confirmed only if the line is still low at the eighth tick after the falling edge was first seen. A shorter low pulse stores nothing.
- R7: A character that completes while the queue holds 16 entries and no byte is read that cycle is discarded and sets status bit 1. The queued bytes are unchanged.
- R8: A status-read strobe clears status bits 1 to 4 in the next cycle, unless a new event sets them in the same cycle.
- R9: Status bit 7 is set when a character with any error flag enters the queue. A status read clears it only if no flagged entry remains queued.
- R10: Bytes come out in arrival order. A data-read strobe with an empty queue has no effect.
- R11: A pulse on `q_flush` empties the queue, and data ready drops to 0.
- R12: `fill_flag` is 1 when the queued count is at least 1, 4, 8 or 14 for `fill_code` 00, 01, 10 and 11.
- R13: Status bits 5 and 6 follow `tx_hold_empty` and `tx_idle`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial line, idle high |
| os_tick | input | 1 | Oversampling enable, 16 per bit |
| char_len | input | 2 | Data bit count code |
| par_on | input | 1 | Parity bit present |
| par_kind | input | 2 | Parity sense code |
| q_flush | input | 1 | Empty the receive queue |
| fill_code | input | 2 | Fill-flag threshold code |
| pop_byte | input | 1 | Remove the oldest byte |
| read_status | input | 1 | Status read strobe (clears sticky bits) |
| tx_hold_empty | input | 1 | Transmitter holding stage empty |
| tx_idle | input | 1 | Transmitter fully idle |
| rx_byte | output | 8 | Oldest queued byte, 0 when empty |
| line_status | output | 8 | Line status byte |
| fill_flag | output | 1 | Queue fill at or above threshold |

## Verification
The assertions assume that the frame-format inputs stay constant while a character is in flight. They also assume that `q_flush` and the read strobes are single-cycle pulses that are never held across an edge they should not affect. The stimulus changes `char_len`, `par_on` and `par_kind` only while the line is idle. It issues every strobe as a one-cycle pulse between characters, or in long gaps after the last stop position. Line transitions have no fixed phase to `os_tick`, so mid-bit sampling gets some margin, but no transition ever falls within a few ticks of a sampling point.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int OSR      = 16;
    localparam int OSR_W    = $clog2(OSR);
    localparam int MID_TICK = OSR / 2;

    typedef enum logic [1:0] {
        PAR_ODD   = 2'b00,
        PAR_EVEN  = 2'b01,
        PAR_ONE   = 2'b10,
        PAR_ZERO  = 2'b11
    } par_kind_t;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_HOLD
    } rx_state_t;

    typedef struct packed {
        logic       brk;
        logic       ferr;
        logic       perr;
        logic [7:0] data;
    } rx_entry_t;

    function automatic logic [3:0] data_bits(input logic [1:0] code);
        return 4'd5 + {2'b00, code};
    endfunction

    function automatic logic [4:0] fill_level(input logic [1:0] code);
        case (code)
            2'b00:   return 5'd1;
            2'b01:   return 5'd4;
            2'b10:   return 5'd8;
            default: return 5'd14;
        endcase
    endfunction

    function automatic logic want_parity(input par_kind_t k, input logic [7:0] d,
                                         input logic [3:0] n);
        logic [7:0] mask;
        logic       x;
        mask = 8'hFF >> (4'd8 - n);
        x    = ^(d & mask);
        case (k)
            PAR_ODD:  return ~x;
            PAR_EVEN: return x;
            PAR_ONE:  return 1'b1;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       line,
    input  logic       tick,
    input  logic [1:0] char_len,
    input  logic       par_on,
    input  logic [1:0] par_kind,
    output logic       done,
    output rx_entry_t  result
);
    rx_state_t        state;
    logic [OSR_W-1:0] cnt;
    logic [2:0]       bidx;
    logic [7:0]       shreg;
    logic             par_bit;
    logic             saw_one;
    logic [3:0]       nbits;
    logic             bit_end;
    logic             is_brk;

    assign nbits   = data_bits(char_len);
    assign bit_end = tick && (cnt == OSR_W'(OSR - 1));
    assign is_brk  = !line && !saw_one;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RX_IDLE;
            cnt     <= '0;
            bidx    <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
            saw_one <= 1'b0;
            done    <= 1'b0;
            result  <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                RX_IDLE: begin
                    if (tick && !line) begin
                        state   <= RX_START;
                        cnt     <= '0;
                        bidx    <= '0;
                        shreg   <= '0;
                        saw_one <= 1'b0;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (cnt == OSR_W'(MID_TICK - 1)) begin
                            cnt   <= '0;
                            state <= line ? RX_IDLE : RX_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                RX_DATA: begin
                    if (bit_end) begin
                        cnt         <= '0;
                        shreg[bidx] <= line;
                        saw_one     <= saw_one | line;
                        if ({1'b0, bidx} == nbits - 4'd1)
                            state <= par_on ? RX_PAR : RX_STOP;
                        else
                            bidx <= bidx + 1'b1;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_PAR: begin
                    if (bit_end) begin
                        cnt     <= '0;
                        par_bit <= line;
                        saw_one <= saw_one | line;
                        state   <= RX_STOP;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (bit_end) begin
                        cnt         <= '0;
                        done        <= 1'b1;
                        result.data <= shreg;
                        result.brk  <= is_brk;
                        result.ferr <= !line && saw_one;
                        result.perr <= par_on && !is_brk &&
                                       (par_bit != want_parity(par_kind_t'(par_kind), shreg, nbits));
                        state       <= line ? RX_IDLE : RX_HOLD;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (line) state <= RX_IDLE;
                end
            endcase
        end
    end

    // A break character always carries an all-zero byte (R5).
    assert_break_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (done && result.brk) |-> (result.data == 8'h00));

    // A start that fails validation never produces a character (R6).
    assert_no_false_start_R6: assert property (@(posedge clk) disable iff (rst)
        (state == RX_START && tick && cnt == OSR_W'(MID_TICK - 1) && line) |=> (state == RX_IDLE));
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              push,
    input  rx_entry_t         wentry,
    input  logic              pop,
    output rx_entry_t         head,
    output logic [$clog2(DEPTH):0] count,
    output logic              accepted,
    output logic              overrun,
    output logic              err_queued
);
    localparam int AW = $clog2(DEPTH);

    rx_entry_t     mem [DEPTH];
    logic [AW:0]   wp, rp;
    logic          do_pop;

    assign count    = wp - rp;
    assign do_pop   = pop && (count != '0) && !flush;
    assign accepted = push && !flush && ((count != (AW+1)'(DEPTH)) || do_pop);
    assign overrun  = push && !flush && (count == (AW+1)'(DEPTH)) && !do_pop;
    assign head     = mem[rp[AW-1:0]];

    always_comb begin
        err_queued = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            logic [AW-1:0] off;
            off = AW'(i) - rp[AW-1:0];
            if (({1'b0, off} < count) && (mem[i].perr || mem[i].ferr || mem[i].brk))
                err_queued = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp <= '0;
            rp <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (flush) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (accepted) begin
                mem[wp[AW-1:0]] <= wentry;
                wp <= wp + 1'b1;
            end
            if (do_pop) rp <= rp + 1'b1;
        end
    end

    assert_count_bound_R10: assert property (@(posedge clk) disable iff (rst)
        count <= (AW+1)'(DEPTH));

    assert_full_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (count == (AW+1)'(DEPTH) && push && !pop && !flush) |=> (count == (AW+1)'(DEPTH)));

    assert_flush_empties_R11: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0));
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status (
    input  logic       clk,
    input  logic       rst,
    input  logic       rd,
    input  logic       set_ovr,
    input  logic       set_par,
    input  logic       set_frm,
    input  logic       set_brk,
    input  logic       err_left,
    input  logic       ready,
    input  logic       hold_empty,
    input  logic       idle,
    output logic [7:0] status
);
    logic ovr, par, frm, brk, qerr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ovr  <= 1'b0;
            par  <= 1'b0;
            frm  <= 1'b0;
            brk  <= 1'b0;
            qerr <= 1'b0;
        end else begin
            ovr  <= set_ovr | (ovr & !rd);
            par  <= set_par | (par & !rd);
            frm  <= set_frm | (frm & !rd);
            brk  <= set_brk | (brk & !rd);
            qerr <= (set_par | set_frm | set_brk) | (qerr & !(rd && !err_left));
        end
    end

    assign status = {qerr, idle, hold_empty, brk, frm, par, ovr, ready};

    assert_ovr_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (rd && !set_ovr) |=> !status[1]);

    assert_ovr_set_R7: assert property (@(posedge clk) disable iff (rst)
        set_ovr |=> status[1]);

    assert_qerr_kept_R9: assert property (@(posedge clk) disable iff (rst)
        (status[7] && err_left) |=> status[7]);
endmodule

// File: rtl/uart_rx_linestat.sv
module uart_rx_linestat
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rxd,
    input  logic       os_tick,
    input  logic [1:0] char_len,
    input  logic       par_on,
    input  logic [1:0] par_kind,
    input  logic       q_flush,
    input  logic [1:0] fill_code,
    input  logic       pop_byte,
    input  logic       read_status,
    input  logic       tx_hold_empty,
    input  logic       tx_idle,
    output logic [7:0] rx_byte,
    output logic [7:0] line_status,
    output logic       fill_flag
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic      sync1, sync2;
    logic      done;
    rx_entry_t fresh, head;
    logic [CW-1:0] count;
    logic      accepted, overrun, err_queued;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
        end else begin
            sync1 <= rxd;
            sync2 <= sync1;
        end
    end

    uart_rx_frame u_frame (
        .clk(clk), .rst(rst), .line(sync2), .tick(os_tick),
        .char_len(char_len), .par_on(par_on), .par_kind(par_kind),
        .done(done), .result(fresh)
    );

    uart_rx_queue #(.DEPTH(DEPTH)) u_queue (
        .clk(clk), .rst(rst), .flush(q_flush), .push(done), .wentry(fresh),
        .pop(pop_byte), .head(head), .count(count), .accepted(accepted),
        .overrun(overrun), .err_queued(err_queued)
    );

    uart_rx_status u_status (
        .clk(clk), .rst(rst), .rd(read_status), .set_ovr(overrun),
        .set_par(accepted && fresh.perr), .set_frm(accepted && fresh.ferr),
        .set_brk(accepted && fresh.brk), .err_left(err_queued),
        .ready(count != '0), .hold_empty(tx_hold_empty), .idle(tx_idle),
        .status(line_status)
    );

    assign rx_byte   = (count != '0) ? head.data : 8'h00;
    assign fill_flag = (count >= CW'(fill_level(fill_code)));

    assert_ready_tracks_R1: assert property (@(posedge clk) disable iff (rst)
        (count == '0) |-> (line_status[0] == 1'b0 && rx_byte == 8'h00));
endmodule

// File: tb/uart_rx_linestat_test.sv
module uart_rx_linestat_test;
    localparam int TDIV = 4;
    localparam int BITCLK = 16 * TDIV;

    logic clk = 0, rst = 1, rxd = 1, os_tick = 0;
    logic [1:0] char_len = 2'b11, par_kind = 2'b00, fill_code = 2'b00;
    logic par_on = 0, q_flush = 0, pop_byte = 0, read_status = 0;
    logic tx_hold_empty = 0, tx_idle = 0;
    logic [7:0] rx_byte, line_status;
    logic fill_flag;
    int runs = 0, fails = 0;
    bit finished = 0;

    uart_rx_linestat uut (.*);

    always #2 clk = ~clk;

    initial begin
        int tc = 0;
        forever begin
            @(negedge clk);
            os_tick = (tc == TDIV - 1);
            tc = (tc == TDIV - 1) ? 0 : tc + 1;
        end
    end

    task automatic chk(string tag, int act, int exp);
        runs++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic send_bit(logic b);
        rxd = b;
        repeat (BITCLK) @(negedge clk);
    endtask

    task automatic send_char(logic [7:0] d, int n, logic pen, logic pbit, logic stop);
        send_bit(0);
        for (int i = 0; i < n; i++) send_bit(d[i]);
        if (pen) send_bit(pbit);
        send_bit(stop);
        send_bit(1);
    endtask

    task automatic pulse_pop();
        pop_byte = 1; @(negedge clk); pop_byte = 0; @(negedge clk);
    endtask

    task automatic pulse_stat();
        read_status = 1; @(negedge clk); read_status = 0; @(negedge clk);
    endtask

    task automatic flush();
        q_flush = 1; @(negedge clk); q_flush = 0; @(negedge clk);
        pulse_stat(); pulse_stat();
    endtask

    task automatic t_reset();
        chk("R1 reset status", line_status, 8'h00);
        chk("R1 reset byte", rx_byte, 8'h00);
        chk("R12 reset fill", fill_flag, 0);
    endtask

    task automatic t_basic();
        send_char(8'hA5, 8, 0, 0, 1);
        chk("R1 byte", rx_byte, 8'hA5);
        chk("R1 ready", line_status[0], 1);
        chk("R1 no errors", line_status[4:1], 0);
        pulse_pop();
        chk("R1 ready drops", line_status[0], 0);
    endtask

    task automatic t_len();
        char_len = 2'b00;
        send_char(8'hF5, 5, 0, 0, 1);
        chk("R2 five bits", rx_byte, 8'h15);
        pulse_pop();
        char_len = 2'b01;
        send_char(8'hFF, 6, 0, 0, 1);
        chk("R2 six bits", rx_byte, 8'h3F);
        pulse_pop();
        char_len = 2'b10;
        send_char(8'h41, 7, 0, 0, 1);
        chk("R2 seven bits", rx_byte, 8'h41);
        pulse_pop();
        char_len = 2'b11;
    endtask

    task automatic t_parity();
        par_on = 1; par_kind = 2'b00;
        send_char(8'h5A, 8, 1, 1, 1);
        chk("R3 odd good", line_status[2], 0);
        pulse_pop();
        par_kind = 2'b01;
        send_char(8'h5A, 8, 1, 1, 1);
        chk("R3 even bad", line_status[2], 1);
        chk("R9 qerr set", line_status[7], 1);
        chk("R3 byte kept", rx_byte, 8'h5A);
        pulse_stat();
        chk("R8 pe cleared", line_status[2], 0);
        chk("R9 qerr held", line_status[7], 1);
        pulse_pop();
        pulse_stat();
        chk("R9 qerr cleared", line_status[7], 0);
        par_kind = 2'b10;
        send_char(8'h00, 8, 1, 0, 1);
        chk("R3 mark bad", line_status[2], 1);
        pulse_pop(); pulse_stat();
        par_kind = 2'b11;
        send_char(8'h00, 8, 1, 0, 1);
        chk("R3 space good", line_status[2], 0);
        pulse_pop();
        par_on = 0;
    endtask

    task automatic t_frame();
        send_char(8'h33, 8, 0, 0, 0);
        chk("R4 fe", line_status[3], 1);
        chk("R4 byte", rx_byte, 8'h33);
        chk("R4 no break", line_status[4], 0);
        pulse_pop(); pulse_stat();
        chk("R8 fe cleared", line_status[3], 0);
    endtask

    task automatic t_break();
        rxd = 0;
        repeat (20 * BITCLK) @(negedge clk);
        rxd = 1;
        repeat (2 * BITCLK) @(negedge clk);
        chk("R5 break flag", line_status[4], 1);
        chk("R5 zero byte", rx_byte, 0);
        pulse_pop();
        chk("R5 single entry", line_status[0], 0);
        pulse_stat();
        chk("R8 bi cleared", line_status[4], 0);
    endtask

    task automatic t_glitch();
        rxd = 0;
        repeat (5 * TDIV) @(negedge clk);
        rxd = 1;
        repeat (12 * BITCLK) @(negedge clk);
        chk("R6 glitch ignored", line_status[0], 0);
    endtask

    task automatic t_overrun();
        flush();
        fill_code = 2'b11;
        for (int i = 0; i < 16; i++) begin
            send_char(8'(i + 8'h10), 8, 0, 0, 1);
            if (i == 12) chk("R12 below 14", fill_flag, 0);
        end
        chk("R12 at 14+", fill_flag, 1);
        chk("R7 no ovr yet", line_status[1], 0);
        send_char(8'hEE, 8, 0, 0, 1);
        chk("R7 ovr set", line_status[1], 1);
        pulse_stat();
        chk("R8 ovr cleared", line_status[1], 0);
        for (int i = 0; i < 16; i++) begin
            chk("R10 order", rx_byte, i + 8'h10);
            pulse_pop();
        end
        chk("R7 drained", line_status[0], 0);
        pulse_pop();
        chk("R10 empty pop", rx_byte, 0);
        send_char(8'h77, 8, 0, 0, 1);
        chk("R10 after empty pop", rx_byte, 8'h77);
        pulse_pop();
    endtask

    task automatic t_fill_flush();
        fill_code = 2'b01;
        for (int i = 0; i < 3; i++) send_char(8'h01, 8, 0, 0, 1);
        chk("R12 3 of 4", fill_flag, 0);
        send_char(8'h02, 8, 0, 0, 1);
        chk("R12 4 of 4", fill_flag, 1);
        fill_code = 2'b10; @(negedge clk);
        chk("R12 4 of 8", fill_flag, 0);
        fill_code = 2'b00; @(negedge clk);
        chk("R12 4 of 1", fill_flag, 1);
        q_flush = 1; @(negedge clk); q_flush = 0; @(negedge clk);
        chk("R11 flushed", line_status[0], 0);
        chk("R11 fill low", fill_flag, 0);
    endtask

    task automatic t_tx();
        tx_hold_empty = 1; tx_idle = 0; @(negedge clk);
        chk("R13 bit5", line_status[6:5], 2'b01);
        tx_hold_empty = 0; tx_idle = 1; @(negedge clk);
        chk("R13 bit6", line_status[6:5], 2'b10);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        repeat (4) @(negedge clk);
        t_reset();
        t_basic();
        t_len();
        t_parity();
        t_frame();
        t_break();
        t_glitch();
        t_overrun();
        t_fill_flush();
        t_tx();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", runs, fails);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            runs++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", runs, fails);
            $finish;
        end
    end
endmodule